// File: doc/BRIEF.md
# Register Transfer and Step Execution Unit

This unit carries out the register-transfer group of a small 8-bit processor. It keeps seven 8-bit scratchpad registers: an accumulator, four general registers, and a high/low pair that together form a 14-bit memory pointer. It accepts one already-fetched opcode byte, plus an immediate byte when the opcode needs one. It then performs one of these operations: a register-to-register copy, a load from memory, a store to memory, a load of the immediate, a store of the immediate to memory, or a one-step increment or decrement. Zero, sign and parity flags are kept here. Carry belongs to the arithmetic group and is not touched.

A controller pulses `start` with the opcode while the unit is idle. Operations that stay inside the register file finish at that clock edge, and `done` pulses in the following cycle. Operations on memory enter the state `ST_MEM`. In that state the unit holds `mem_req` and a stable address and data until `mem_ready` is seen, then returns to `ST_IDLE` and pulses `done`. The all-ones opcode moves the unit to `ST_HALT`, where it stays until reset. The named transitions are: IDLE→IDLE for a register operation or a rejected opcode, IDLE→MEM for a memory operation, MEM→MEM while waiting, MEM→IDLE on ready, and IDLE→HALT on the halt opcode. A read port (`reg_sel`/`reg_view`) lets the surrounding core view any register.

Top module: `regmove_unit`

## Requirements
- R1: While reset is low and after it is released, all seven registers and the zero, sign and parity flags read 0, and `mem_req`, `done`, `illegal` and `halt` are low.
- R2: Register codes are A=000, B=001, C=010, D=011, E=100, H=101, L=110. Code 111 selects memory. Opcode `11 ddd sss` with neither field equal to 111 copies register sss into register ddd. `done` pulses in the cycle after `start` is taken, and the flags do not change.
- R3: Opcode `00 ddd 110` with ddd≠111 writes the `imm` byte into register ddd. The flags do not change.
- R4: Every memory access uses the address {H[5:0], L}. The two upper bits of H are ignored.
- R5: Opcode `11 ddd 111` (ddd≠111) raises `mem_req` with `mem_we`=0 in the cycle after `start`. Request, address and write flag stay fixed until `mem_ready` is high. `mem_rdata` in that ready cycle is written to register ddd, and `done` pulses in the next cycle with `mem_req` low.
- R6: Opcode `11 111 sss` (sss≠111) performs a memory write (`mem_we`=1) with `mem_wdata` equal to register sss. It uses the same handshake as R5.
- R7: Opcode `00 111 110` writes the `imm` byte to memory using the handshake of R5.
- R8: Opcode `00 ddd 000` adds one to register ddd and `00 ddd 001` subtracts one, for ddd in B..L. Results wrap modulo 256.
- R9: Increment and decrement set zero when the result is 0x00, set sign to result bit 7, and set parity when the result has an even number of ones. No other operation changes a flag.
- R10: Increment or decrement with ddd=000 or ddd=111, and any opcode outside this group (for example `01 xxx xxx`), raise `illegal` together with `done` for one cycle and change no register or flag.
- R11: Opcode `11 111 111` raises `halt`, which stays high until reset. While halted, `start` is ignored and `done` stays low.
- R12: A `start` that arrives while a memory access is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opcode valid; taken only in the idle state |
| opcode | input | 8 | Decoded instruction byte |
| imm | input | 8 | Immediate byte for the immediate forms |
| reg_sel | input | 3 | Register code to show on `reg_view` |
| reg_view | output | 8 | Current value of the selected register |
| zero | output | 1 | Zero flag |
| sign | output | 1 | Sign flag |
| parity | output | 1 | Even-parity flag |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 14 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, sampled when `mem_ready` is high |
| mem_ready | input | 1 | Access completes in this cycle |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for a rejected opcode |
| halt | output | 1 | Halted, held until reset |

## Verification
Moves are tried between several different register pairs, with loaded values that are distinct, so a swapped source or destination field shows up as a wrong byte. Increment and decrement are run through 0xFF→0x00 and 0x00→0xFF, where wrap, zero, sign and parity all change at once, and on a value with an odd number of ones, which separates even from odd parity. Memory operations run with a zero-wait ready and with a multi-cycle wait. During the wait a competing `start` is applied, and H carries set upper bits that must not reach the address. Rejected opcodes and the halt opcode are followed by register and flag reads to confirm that nothing moved.

// File: rtl/regmove_pkg.sv
package regmove_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MEM,
        ST_HALT
    } state_t;

    typedef enum logic [3:0] {
        K_MOV,
        K_LDM,
        K_STM,
        K_LDI,
        K_STI,
        K_INC,
        K_DEC,
        K_HALT,
        K_BAD
    } kind_t;

    typedef struct packed {
        kind_t      kind;
        logic [2:0] dst;
        logic [2:0] src;
    } dec_t;

    localparam logic [2:0] CODE_ACC = 3'd0;
    localparam logic [2:0] CODE_MEM = 3'd7;
    localparam int         IDX_HI   = 5;
    localparam int         IDX_LO   = 6;

endpackage

// File: rtl/regmove_decode.sv
module regmove_decode
    import regmove_pkg::*;
(
    input  logic [7:0] op,
    output dec_t       dec
);
    logic [1:0] grp;
    logic [2:0] fd;
    logic [2:0] fs;

    assign grp = op[7:6];
    assign fd  = op[5:3];
    assign fs  = op[2:0];

    always_comb begin
        dec.dst  = fd;
        dec.src  = fs;
        dec.kind = K_BAD;
        if (grp == 2'b11) begin
            if (fd == CODE_MEM && fs == CODE_MEM)
                dec.kind = K_HALT;
            else if (fs == CODE_MEM)
                dec.kind = K_LDM;
            else if (fd == CODE_MEM)
                dec.kind = K_STM;
            else
                dec.kind = K_MOV;
        end else if (grp == 2'b00) begin
            unique case (fs)
                3'b110:  dec.kind = (fd == CODE_MEM) ? K_STI : K_LDI;
                3'b000:  dec.kind = (fd == CODE_ACC || fd == CODE_MEM) ? K_BAD : K_INC;
                3'b001:  dec.kind = (fd == CODE_ACC || fd == CODE_MEM) ? K_BAD : K_DEC;
                default: dec.kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/regmove_regfile.sv
module regmove_regfile
    import regmove_pkg::*;
#(
    parameter int DW   = 8,
    parameter int AW   = 14,
    parameter int NREG = 7,
    localparam int RW  = $clog2(NREG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [RW-1:0] ra,
    output logic [DW-1:0] rdata_a,
    input  logic [RW-1:0] rv,
    output logic [DW-1:0] rdata_v,
    output logic [AW-1:0] ptr
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && waddr == RW'(g))
                regs[g] <= wdata;
        end
    end

    always_comb begin
        rdata_a = '0;
        rdata_v = '0;
        for (int i = 0; i < NREG; i++) begin
            if (ra == RW'(i)) rdata_a = regs[i];
            if (rv == RW'(i)) rdata_v = regs[i];
        end
    end

    assign ptr = {regs[IDX_HI][AW-DW-1:0], regs[IDX_LO]};
endmodule

// File: rtl/regmove_stepper.sv
module regmove_stepper #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] operand,
    input  logic          down,
    input  logic          upd,
    output logic [DW-1:0] result,
    output logic          zero,
    output logic          sign,
    output logic          parity
);
    assign result = down ? operand - DW'(1) : operand + DW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero   <= 1'b0;
            sign   <= 1'b0;
            parity <= 1'b0;
        end else if (upd) begin
            zero   <= (result == '0);
            sign   <= result[DW-1];
            parity <= ~^result;
        end
    end
endmodule

// File: rtl/regmove_unit.sv
module regmove_unit
    import regmove_pkg::*;
#(
    parameter int DW   = 8,
    parameter int AW   = 14,
    parameter int NREG = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    opcode,
    input  logic [DW-1:0] imm,
    input  logic [2:0]    reg_sel,
    output logic [DW-1:0] reg_view,
    output logic          zero,
    output logic          sign,
    output logic          parity,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          done,
    output logic          illegal,
    output logic          halt
);
    state_t        state_q, state_d;
    dec_t          dec;
    logic          accept;
    logic          mem_op;
    logic          finish;
    logic          wr_en;
    logic [2:0]    wr_addr;
    logic [DW-1:0] wr_data;
    logic [DW-1:0] src_data;
    logic [DW-1:0] step_res;
    logic [AW-1:0] ptr;
    logic [2:0]    dst_q;
    logic          step_upd;

    regmove_decode u_dec (
        .op  (opcode),
        .dec (dec)
    );

    regmove_regfile #(.DW(DW), .AW(AW), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .ra      (dec.kind == K_INC || dec.kind == K_DEC ? dec.dst : dec.src),
        .rdata_a (src_data),
        .rv      (reg_sel),
        .rdata_v (reg_view),
        .ptr     (ptr)
    );

    regmove_stepper #(.DW(DW)) u_step (
        .clk     (clk),
        .rst_n   (rst_n),
        .operand (src_data),
        .down    (dec.kind == K_DEC),
        .upd     (step_upd),
        .result  (step_res),
        .zero    (zero),
        .sign    (sign),
        .parity  (parity)
    );

    assign accept   = (state_q == ST_IDLE) && start;
    assign mem_op   = (dec.kind == K_LDM) || (dec.kind == K_STM) || (dec.kind == K_STI);
    assign finish   = (state_q == ST_MEM) && mem_ready;
    assign step_upd = accept && (dec.kind == K_INC || dec.kind == K_DEC);
    assign mem_req  = (state_q == ST_MEM);

    // register write port: immediate-path ops at acceptance, loads at ready
    always_comb begin
        wr_en   = 1'b0;
        wr_addr = dec.dst;
        wr_data = src_data;
        if (finish) begin
            wr_en   = !mem_we;
            wr_addr = dst_q;
            wr_data = mem_rdata;
        end else if (accept) begin
            unique case (dec.kind)
                K_MOV:   begin wr_en = 1'b1; wr_data = src_data; end
                K_LDI:   begin wr_en = 1'b1; wr_data = imm;      end
                K_INC,
                K_DEC:   begin wr_en = 1'b1; wr_data = step_res; end
                default: wr_en = 1'b0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start && mem_op)               state_d = ST_MEM;
                else if (start && dec.kind == K_HALT) state_d = ST_HALT;
            end
            ST_MEM:  if (mem_ready) state_d = ST_IDLE;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done      <= 1'b0;
            illegal   <= 1'b0;
            halt      <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            dst_q     <= '0;
        end else begin
            done    <= finish || (accept && !mem_op && dec.kind != K_HALT);
            illegal <= accept && dec.kind == K_BAD;
            if (accept && dec.kind == K_HALT) halt <= 1'b1;
            if (accept && mem_op) begin
                mem_we    <= (dec.kind != K_LDM);
                mem_addr  <= ptr;
                mem_wdata <= (dec.kind == K_STI) ? imm : src_data;
                dst_q     <= dec.dst;
            end
        end
    end
endmodule

// File: rtl/regmove_checker.sv
module regmove_checker #(
    parameter int DW = 8,
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          zero,
    input logic          sign,
    input logic          parity,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          mem_ready,
    input logic          done,
    input logic          illegal,
    input logic          halt
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> !mem_req && !done && !illegal && !halt);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_done_after_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready |=> done && !mem_req);

    assert_flags_move_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({zero, sign, parity}) |-> done && !illegal);

    assert_illegal_has_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> done && !mem_req);

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !mem_req && !done);
endmodule

bind regmove_unit regmove_checker #(.DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .zero      (zero),
    .sign      (sign),
    .parity    (parity),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .done      (done),
    .illegal   (illegal),
    .halt      (halt)
);

// File: tb/regmove_unit_bench.sv
module regmove_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [7:0]  imm = '0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_view;
    logic        zero, sign, parity;
    logic        mem_req, mem_we;
    logic [13:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic        done, illegal, halt;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    regmove_unit u_regmove_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm(imm),
        .reg_sel(reg_sel), .reg_view(reg_view), .zero(zero), .sign(sign),
        .parity(parity), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .done(done), .illegal(illegal), .halt(halt)
    );

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input logic [2:0] sel, input logic [7:0] exp, input string tag);
        reg_sel = sel;
        #0.5;
        chk({8'h0, reg_view}, {8'h0, exp}, tag);
    endtask

    task automatic chk_flags(input logic z, input logic s, input logic p, input string tag);
        chk({13'h0, zero, sign, parity}, {13'h0, z, s, p}, tag);
    endtask

    // one-cycle operation: start at a falling edge, observe after the next rising edge
    task automatic issue(input logic [7:0] op, input logic [7:0] b);
        start = 1'b1; opcode = op; imm = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 7; i++) chk_reg(3'(i), 8'h00, "R1 reg after reset");
        chk_flags(0, 0, 0, "R1 flags after reset");
        chk({12'h0, mem_req, done, illegal, halt}, 16'h0, "R1 outputs after reset");
    endtask

    task automatic t_load_imm;
        issue(8'h0E, 8'h3C); chk({15'h0, done}, 16'h1, "R3 done after load imm");
        chk_reg(3'd1, 8'h3C, "R3 B loaded");
        issue(8'h2E, 8'hC5); issue(8'h36, 8'h7A); issue(8'h06, 8'h81);
        chk_reg(3'd5, 8'hC5, "R3 H loaded");
        chk_reg(3'd0, 8'h81, "R3 A loaded");
        chk_flags(0, 0, 0, "R3 flags untouched by load");
    endtask

    task automatic t_move;
        issue(8'hD1, 8'h00); chk({15'h0, done}, 16'h1, "R2 done after move");
        chk_reg(3'd2, 8'h3C, "R2 C=B");
        issue(8'hD8, 8'h00); chk_reg(3'd3, 8'h81, "R2 D=A");
        chk_reg(3'd0, 8'h81, "R2 source A kept");
        chk_flags(0, 0, 0, "R2 flags untouched by move");
    endtask

    task automatic t_step;
        issue(8'h08, 8'h00); chk_reg(3'd1, 8'h3D, "R8 inc B");
        chk_flags(0, 0, 0, "R9 flags 0x3D odd parity");
        issue(8'h26, 8'hFF); issue(8'h20, 8'h00);
        chk_reg(3'd4, 8'h00, "R8 inc E wraps");
        chk_flags(1, 0, 1, "R9 flags zero");
        issue(8'h21, 8'h00);
        chk_reg(3'd4, 8'hFF, "R8 dec E wraps");
        chk_flags(0, 1, 1, "R9 flags 0xFF");
        issue(8'hD3, 8'h00);
        chk_flags(0, 1, 1, "R9 move keeps flags");
    endtask

    task automatic t_illegal;
        logic [7:0] ops [4] = '{8'h00, 8'h01, 8'h38, 8'h42};
        for (int i = 0; i < 4; i++) begin
            issue(ops[i], 8'h00);
            chk({14'h0, done, illegal}, 16'h3, "R10 illegal pulse");
            @(negedge clk);
            chk({15'h0, illegal}, 16'h0, "R10 illegal one cycle");
        end
        chk_reg(3'd0, 8'h81, "R10 A unchanged");
        chk_flags(0, 1, 1, "R10 flags unchanged");
    endtask

    task automatic t_mem_load;
        issue(8'hCF, 8'h00);
        chk({14'h0, mem_req, mem_we}, 16'h2, "R5 read request");
        chk({2'h0, mem_addr}, 16'h057A, "R4 address drops H upper bits");
        // competing start while pending: MOV E,D must not happen
        start = 1'b1; opcode = 8'hE3;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk({15'h0, mem_req}, 16'h1, "R5 request held");
        chk({15'h0, done}, 16'h0, "R5 no done while waiting");
        mem_ready = 1'b1; mem_rdata = 8'h5A;
        @(negedge clk); mem_ready = 1'b0; mem_rdata = 8'h00;
        chk({14'h0, done, mem_req}, 16'h2, "R5 done after ready");
        chk_reg(3'd1, 8'h5A, "R5 B from memory");
        chk_reg(3'd4, 8'hFF, "R12 start ignored while pending");
    endtask

    task automatic t_mem_store;
        issue(8'hFB, 8'h00);
        chk({14'h0, mem_req, mem_we}, 16'h3, "R6 write request");
        chk({8'h0, mem_wdata}, 16'h0081, "R6 write data is D");
        mem_ready = 1'b1;
        @(negedge clk); mem_ready = 1'b0;
        chk({14'h0, done, mem_req}, 16'h2, "R6 done zero-wait");
        issue(8'h36, 8'h10);
        issue(8'h3E, 8'h99);
        chk({14'h0, mem_req, mem_we}, 16'h3, "R7 write request");
        chk({8'h0, mem_wdata}, 16'h0099, "R7 write data is imm");
        chk({2'h0, mem_addr}, 16'h0510, "R4 address follows L");
        @(negedge clk); mem_ready = 1'b1;
        @(negedge clk); mem_ready = 1'b0;
        chk({15'h0, done}, 16'h1, "R7 done");
    endtask

    task automatic t_halt;
        issue(8'hFF, 8'h00);
        chk({14'h0, halt, done}, 16'h2, "R11 halt raised");
        issue(8'h0E, 8'h77);
        chk({14'h0, halt, done}, 16'h2, "R11 halt kept, no done");
        chk_reg(3'd1, 8'h5A, "R11 start ignored while halted");
        rst_n = 1'b0; @(negedge clk);
        chk({15'h0, halt}, 16'h0, "R1 halt cleared by reset");
        chk_reg(3'd1, 8'h00, "R1 B cleared by reset");
        rst_n = 1'b1; @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_imm();
        t_move();
        t_step();
        t_illegal();
        t_mem_load();
        t_mem_store();
        t_halt();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule